// File: doc/BRIEF.md
# Multi-Cycle Core Sequencing Controller

This block is the sequencer of a small 32-bit core that runs each instruction over several clock cycles. The core shares one memory between instructions and data, and it has a single ALU. The controller reads the 6-bit opcode from the instruction register. It then walks through a chain of states: fetch, decode, then a short path that depends on the instruction class. In every state it drives one fixed pattern on the datapath's steering and write-enable lines.

Five instruction classes are supported: word load, word store, register-to-register arithmetic, branch-if-equal and unconditional jump. Fetch and decode are common to all of them. After that, each class takes its own path of one to three further states and then goes back to fetch. A load takes 5 cycles, a store 4, an arithmetic operation 4, and a branch or jump 3. An opcode outside the supported set returns to fetch straight after decode. The registers, memory and ALU of the datapath are outside this block.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the outputs show the fetch pattern. Asserting `rst_n` low in the middle of an instruction returns the block to fetch at once.
- R2: Fetch pattern: `pc_wr`=1, `mem_rd`=1, `ir_wr`=1, `alu_b_sel`=01 (constant four), `alu_fn`=00 (add), `pc_src`=00, `alu_a_reg`=0, `addr_data`=0, and every other line 0. The next state is always decode.
- R3: Decode pattern: `alu_b_sel`=11 (shifted branch offset), `alu_fn`=00, and every other line 0.
- R4: Load (opcode 35) follows decode with three states. Address: `alu_a_reg`=1, `alu_b_sel`=10 (sign-extended immediate), `alu_fn`=00. Read: `addr_data`=1, `mem_rd`=1. Writeback: `reg_wr`=1, `wb_mem`=1, `dst_rd`=0. The load takes 5 cycles in total.
- R5: Store (opcode 43) follows decode with the same address state and then a write state with `addr_data`=1 and `mem_wr`=1. The store takes 4 cycles in total.
- R6: Arithmetic (opcode 0) follows decode with two states. Execute: `alu_a_reg`=1, `alu_b_sel`=00, `alu_fn`=10 (function field). Writeback: `dst_rd`=1, `reg_wr`=1, `wb_mem`=0. The operation takes 4 cycles in total.
- R7: Branch (opcode 4) follows decode with one completion state: `alu_a_reg`=1, `alu_b_sel`=00, `alu_fn`=01 (subtract), `pc_wr_cond`=1, `pc_src`=01. The branch takes 3 cycles in total.
- R8: Jump (opcode 2) follows decode with one completion state: `pc_wr`=1, `pc_src`=10, and every other line 0. The jump takes 3 cycles in total.
- R9: Any other opcode returns to fetch in the cycle after decode.
- R10: The opcode is read only in the decode and address states. A change to the opcode in any other state has no effect on the path.
- R11: `mem_rd` and `mem_wr` are never both 1. `reg_wr` and `pc_wr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write gated by ALU zero |
| addr_data | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| wb_mem | output | 1 | Register write data from memory data register (1) or ALU result (0) |
| dst_rd | output | 1 | Destination from bits 15:11 (1) or bits 20:16 (0) |
| reg_wr | output | 1 | Register file write |
| alu_a_reg | output | 1 | ALU A input from register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU B: 00 reg B, 01 four, 10 immediate, 11 shifted offset |
| alu_fn | output | 2 | ALU operation: 00 add, 01 subtract, 10 by function field |
| pc_src | output | 2 | Next PC: 00 ALU out now, 01 ALU result register, 10 jump target |

## Verification
In the fetch state two functions share one cycle: the instruction register loads from memory and the program counter advances. The controller must raise `ir_wr` and `pc_wr` together, and the bench checks that both are set in the same sample. The opcode also changes in that same fetch cycle, the way a real instruction register updates. The bench then checks that decode branches on the new value, and that later changes in the execute and completion states do not reach the path.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MADDR  = 4'd2,
    S_LDRD   = 4'd3,
    S_LDWB   = 4'd4,
    S_STWR   = 4'd5,
    S_REXE   = 4'd6,
    S_RWB    = 4'd7,
    S_BEQ    = 4'd8,
    S_JMP    = 4'd9
  } step_t;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_data;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_mem;
    logic       dst_rd;
    logic       reg_wr;
    logic       alu_a_reg;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_fn;
    logic [1:0] pc_src;
  } ctl_t;

  localparam logic [1:0] B_REG   = 2'b00;
  localparam logic [1:0] B_FOUR  = 2'b01;
  localparam logic [1:0] B_IMM   = 2'b10;
  localparam logic [1:0] B_BROFF = 2'b11;

  localparam logic [1:0] FN_ADD  = 2'b00;
  localparam logic [1:0] FN_SUB  = 2'b01;
  localparam logic [1:0] FN_FUNC = 2'b10;

  localparam logic [1:0] PC_INC  = 2'b00;
  localparam logic [1:0] PC_BR   = 2'b01;
  localparam logic [1:0] PC_JMP  = 2'b10;

endpackage

// File: rtl/mcyc_next.sv
module mcyc_next
  import mcyc_ctrl_pkg::*;
#(
  parameter int              OP_W  = 6,
  parameter logic [OP_W-1:0] LD_OP = 6'd35,
  parameter logic [OP_W-1:0] ST_OP = 6'd43,
  parameter logic [OP_W-1:0] RT_OP = 6'd0,
  parameter logic [OP_W-1:0] BR_OP = 6'd4,
  parameter logic [OP_W-1:0] JP_OP = 6'd2
) (
  input  step_t           cur,
  input  logic [OP_W-1:0] opcode,
  output step_t           nxt
);

  function automatic step_t after_decode(input logic [OP_W-1:0] op);
    if (op == LD_OP || op == ST_OP) return S_MADDR;
    if (op == RT_OP)                return S_REXE;
    if (op == BR_OP)                return S_BEQ;
    if (op == JP_OP)                return S_JMP;
    return S_FETCH;
  endfunction

  function automatic step_t after_addr(input logic [OP_W-1:0] op);
    return (op == LD_OP) ? S_LDRD : S_STWR;
  endfunction

  always_comb begin
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: nxt = after_decode(opcode);
      S_MADDR:  nxt = after_addr(opcode);
      S_LDRD:   nxt = S_LDWB;
      S_REXE:   nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode
  import mcyc_ctrl_pkg::*;
(
  input  step_t cur,
  output ctl_t  ctl
);

  always_comb begin
    ctl = '0;
    case (cur)
      S_FETCH: begin
        ctl.pc_wr     = 1'b1;
        ctl.mem_rd    = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.alu_b_sel = B_FOUR;
        ctl.alu_fn    = FN_ADD;
        ctl.pc_src    = PC_INC;
      end
      S_DECODE: begin
        ctl.alu_b_sel = B_BROFF;
        ctl.alu_fn    = FN_ADD;
      end
      S_MADDR: begin
        ctl.alu_a_reg = 1'b1;
        ctl.alu_b_sel = B_IMM;
        ctl.alu_fn    = FN_ADD;
      end
      S_LDRD: begin
        ctl.addr_data = 1'b1;
        ctl.mem_rd    = 1'b1;
      end
      S_LDWB: begin
        ctl.reg_wr = 1'b1;
        ctl.wb_mem = 1'b1;
      end
      S_STWR: begin
        ctl.addr_data = 1'b1;
        ctl.mem_wr    = 1'b1;
      end
      S_REXE: begin
        ctl.alu_a_reg = 1'b1;
        ctl.alu_b_sel = B_REG;
        ctl.alu_fn    = FN_FUNC;
      end
      S_RWB: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_wr = 1'b1;
      end
      S_BEQ: begin
        ctl.alu_a_reg  = 1'b1;
        ctl.alu_b_sel  = B_REG;
        ctl.alu_fn     = FN_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = PC_BR;
      end
      S_JMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PC_JMP;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_ctrl_pkg::*;
#(
  parameter int              OP_W  = 6,
  parameter logic [OP_W-1:0] LD_OP = 6'd35,
  parameter logic [OP_W-1:0] ST_OP = 6'd43,
  parameter logic [OP_W-1:0] RT_OP = 6'd0,
  parameter logic [OP_W-1:0] BR_OP = 6'd4,
  parameter logic [OP_W-1:0] JP_OP = 6'd2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            addr_data,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            wb_mem,
  output logic            dst_rd,
  output logic            reg_wr,
  output logic            alu_a_reg,
  output logic [1:0]      alu_b_sel,
  output logic [1:0]      alu_fn,
  output logic [1:0]      pc_src
);

  step_t state_q;
  step_t state_d;
  ctl_t  ctl;

  mcyc_next #(
    .OP_W(OP_W), .LD_OP(LD_OP), .ST_OP(ST_OP),
    .RT_OP(RT_OP), .BR_OP(BR_OP), .JP_OP(JP_OP)
  ) next_i (
    .cur   (state_q),
    .opcode(opcode),
    .nxt   (state_d)
  );

  mcyc_decode decode_i (
    .cur(state_q),
    .ctl(ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_FETCH;
    else        state_q <= state_d;
  end

  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign addr_data  = ctl.addr_data;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign ir_wr      = ctl.ir_wr;
  assign wb_mem     = ctl.wb_mem;
  assign dst_rd     = ctl.dst_rd;
  assign reg_wr     = ctl.reg_wr;
  assign alu_a_reg  = ctl.alu_a_reg;
  assign alu_b_sel  = ctl.alu_b_sel;
  assign alu_fn     = ctl.alu_fn;
  assign pc_src     = ctl.pc_src;

  // Named events for the checks below
  logic fetch_ev;
  logic decode_ev;
  logic addr_ev;
  logic load_wb_ev;
  assign fetch_ev   = (state_q == S_FETCH);
  assign decode_ev  = (state_q == S_DECODE);
  assign addr_ev    = (state_q == S_MADDR);
  assign load_wb_ev = reg_wr && wb_mem;

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |=> (decode_ev && alu_b_sel == B_BROFF));

  // R2
  fetch_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |-> (pc_wr && pc_src == PC_INC));

  // R4
  load_wb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wb_ev |-> $past(mem_rd && addr_data));

  // R5
  store_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(addr_ev));

  // R7
  branch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> (ir_wr && !pc_wr_cond));

  // R8
  jump_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_src == PC_JMP) |=> fetch_ev);

  // R11
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R11
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && pc_wr));

endmodule

// File: tb/mcyc_ctrl_tb_top.sv
module mcyc_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic pc_wr, pc_wr_cond, addr_data, mem_rd, mem_wr, ir_wr;
  logic wb_mem, dst_rd, reg_wr, alu_a_reg;
  logic [1:0] alu_b_sel, alu_fn, pc_src;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mcyc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_data(addr_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_mem(wb_mem),
    .dst_rd(dst_rd), .reg_wr(reg_wr), .alu_a_reg(alu_a_reg),
    .alu_b_sel(alu_b_sel), .alu_fn(alu_fn), .pc_src(pc_src)
  );

  // Vector order: pc_wr pc_wr_cond addr_data mem_rd mem_wr ir_wr wb_mem dst_rd reg_wr alu_a_reg b fn src
  function automatic logic [15:0] pat(input logic pw, pc, ad, mr, mw, iw, wm, dr, rw, aa,
                                      input logic [1:0] b, fn, src);
    return {pw, pc, ad, mr, mw, iw, wm, dr, rw, aa, b, fn, src};
  endfunction

  localparam logic [15:0] P_FETCH  = {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00};
  localparam logic [15:0] P_DECODE = {10'b0, 2'b11, 2'b00, 2'b00};
  localparam logic [15:0] P_ADDR   = {9'b0, 1'b1, 2'b10, 2'b00, 2'b00};
  localparam logic [15:0] P_LDRD   = {2'b00, 1'b1, 1'b1, 12'b0};
  localparam logic [15:0] P_LDWB   = {6'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'b0};
  localparam logic [15:0] P_STWR   = {2'b00, 1'b1, 1'b0, 1'b1, 11'b0};
  localparam logic [15:0] P_REXE   = {9'b0, 1'b1, 2'b00, 2'b10, 2'b00};
  localparam logic [15:0] P_RWB    = {7'b0, 1'b1, 1'b1, 7'b0};
  localparam logic [15:0] P_BEQ    = {1'b0, 1'b1, 7'b0, 1'b1, 2'b00, 2'b01, 2'b01};
  localparam logic [15:0] P_JMP    = {1'b1, 13'b0, 2'b10};

  function automatic logic [15:0] now();
    return pat(pc_wr, pc_wr_cond, addr_data, mem_rd, mem_wr, ir_wr, wb_mem, dst_rd,
               reg_wr, alu_a_reg, alu_b_sel, alu_fn, pc_src);
  endfunction

  task automatic chk(input logic [15:0] exp, input string tag);
    logic [15:0] act;
    act = now();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Sample mid-cycle, then move to the next mid-cycle point
  task automatic step(input logic [15:0] exp, input string tag);
    chk(exp, tag);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #3;
    chk(P_FETCH, "R1 during reset");
    @(negedge clk);
    chk(P_FETCH, "R1 held in reset");
    rst_n = 1'b1;
    step(P_FETCH, "R1 first cycle after reset");
    // back in decode now; finish with unsupported to return to fetch
    opcode = 6'd63;
    step(P_DECODE, "R3 decode after reset");
  endtask

  task automatic t_load();
    opcode = 6'd35;
    step(P_FETCH, "R2 load fetch");
    step(P_DECODE, "R3 load decode");
    step(P_ADDR, "R4 load address");
    step(P_LDRD, "R4 load read");
    step(P_LDWB, "R4 load writeback");
  endtask

  task automatic t_store();
    opcode = 6'd43;
    step(P_FETCH, "R2 store fetch");
    step(P_DECODE, "R3 store decode");
    step(P_ADDR, "R5 store address");
    step(P_STWR, "R5 store write");
  endtask

  task automatic t_rtype();
    opcode = 6'd0;
    step(P_FETCH, "R2 arith fetch");
    step(P_DECODE, "R3 arith decode");
    step(P_REXE, "R6 arith execute");
    step(P_RWB, "R6 arith writeback");
  endtask

  task automatic t_branch();
    opcode = 6'd4;
    step(P_FETCH, "R2 branch fetch");
    step(P_DECODE, "R3 branch decode");
    step(P_BEQ, "R7 branch completion");
  endtask

  task automatic t_jump();
    opcode = 6'd2;
    step(P_FETCH, "R2 jump fetch");
    step(P_DECODE, "R3 jump decode");
    step(P_JMP, "R8 jump completion");
  endtask

  task automatic t_unknown(input logic [5:0] op);
    opcode = op;
    step(P_FETCH, "R2 fetch before unknown");
    step(P_DECODE, "R9 unknown decode");
    chk(P_FETCH, "R9 unknown returns to fetch");
  endtask

  task automatic t_late_opcode();
    opcode = 6'd0;
    step(P_FETCH, "R2 fetch before late change");
    step(P_DECODE, "R3 decode before late change");
    opcode = 6'd35;
    step(P_REXE, "R10 execute with changed opcode");
    opcode = 6'd2;
    step(P_RWB, "R10 writeback kept despite change");
    opcode = 6'd4;
    step(P_FETCH, "R10 fetch after arith");
    step(P_DECODE, "R10 decode sees new opcode");
    opcode = 6'd43;
    step(P_BEQ, "R10 branch with changed opcode");
    chk(P_FETCH, "R10 branch returns to fetch");
  endtask

  task automatic t_reset_mid();
    opcode = 6'd0;
    step(P_FETCH, "R2 fetch before mid reset");
    step(P_DECODE, "R3 decode before mid reset");
    chk(P_REXE, "R6 execute before mid reset");
    rst_n = 1'b0;
    #2;
    chk(P_FETCH, "R1 async reset mid instruction");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_exclusive();
    logic [15:0] v;
    v = now();
    checks++;
    if ((mem_rd && mem_wr) || (reg_wr && pc_wr)) begin
      errors++;
      $display("FAIL R11: actual=%b expected no conflicting enables", v);
    end
  endtask

  initial begin
    t_reset();
    t_load();
    t_store();
    t_rtype();
    t_branch();
    t_jump();
    t_unknown(6'd1);
    t_unknown(6'd63);
    t_late_opcode();
    t_reset_mid();
    // back-to-back load then jump with exclusivity sampled each cycle
    opcode = 6'd35;
    for (int i = 0; i < 5; i++) begin
      t_exclusive();
      @(negedge clk);
    end
    t_jump();
    t_exclusive();
    chk(P_FETCH, "R8 jump returns to fetch");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule